// File: doc/BRIEF.md
# MBIST Compare and Fail-Flag Unit

This block sits at the data-return end of a memory self-test engine. For each read issued by the engine it compares the word returned by the RAM against the expected pattern word, ignoring any bit selected by a per-bit mask, and turns the result into a fail indication for the tester. Address sequencing and pattern generation happen elsewhere; this unit only judges the data and decides what a failure means for the rest of the run.

Each new test instruction loads a 6-bit control word. Its most significant bit picks how the fail output behaves: it can follow every comparison as it happens, or it can latch on the first mismatch and stay high. The failure clear happens on a new instruction or when the tester shifts out the failure log. The five low bits choose a failure policy: carry on to the end, ask the engine to stop at the first mismatch, or emit a log entry (address plus a bit-difference syndrome) for every mismatch so that a failure bitmap can be built.

All outputs are registered and respond in the clock cycle after the compare strobe.

Top module: `mbist_cmp_unit`

## Requirements
- R1: While rst_n is low at a rising edge, fail_bit, end_of_test and log_valid are cleared and the control word returns to 6'b000000 (sticky flag, run-to-end policy).
- R2: With control bit 5 = 1, after each accepted compare fail_bit equals that compare's mismatch result (1 = mismatch, 0 = match) and keeps that value until the next accepted compare.
- R3: With control bit 5 = 0, fail_bit goes high on the first accepted mismatch and stays high through later matching compares.
- R4: With control bit 5 = 0, a log_shift pulse clears fail_bit; a mismatch accepted in the same cycle as log_shift leaves fail_bit high.
- R5: An instr_load pulse loads instr_ctrl and clears fail_bit, end_of_test and log_valid; a compare strobe in the load cycle is ignored.
- R6: Control bits [4:0] = 5'b00000 select run-to-end: mismatches never raise end_of_test or log_valid.
- R7: Control bits [4:0] = 5'b00001 select stop-on-fail: end_of_test rises in the cycle after the first mismatch and holds until the next instr_load; compares while end_of_test is high are ignored.
- R8: Control bits [4:0] = 5'b00011 select bitmap logging: each mismatch gives a one-cycle log_valid in the next cycle, with log_addr = the compare's cmp_addr and log_syndrome = (cmp_act XOR cmp_exp) with masked bits forced to 0.
- R9: Any other value of control bits [4:0] behaves as run-to-end.
- R10: A cmp_mask bit of 1 removes that data bit from the comparison; a difference confined to masked bits is a match.
- R11: Outputs are registered: a compare presented before a rising edge changes fail_bit only after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_load | input | 1 | One-cycle pulse: new instruction, load control word |
| instr_ctrl | input | 6 | Control word; bit 5 flag mode, bits [4:0] failure policy |
| cmp_valid | input | 1 | Compare strobe: read data is valid this cycle |
| cmp_act | input | DATA_W (32) | Data read from the RAM |
| cmp_exp | input | DATA_W (32) | Expected data |
| cmp_mask | input | DATA_W (32) | Per-bit mask, 1 = bit ignored |
| cmp_addr | input | ADDR_W (16) | Address of the word being compared |
| log_shift | input | 1 | One-cycle pulse: failure log shifted out |
| fail_bit | output | 1 | Fail result bit |
| end_of_test | output | 1 | Request to end the test (stop-on-fail) |
| log_valid | output | 1 | One-cycle log entry strobe (bitmap policy) |
| log_addr | output | ADDR_W (16) | Failing address of the log entry |
| log_syndrome | output | DATA_W (32) | Failing bit positions of the log entry |

## Verification
The bench targets the places where the two flag modes diverge: a matching compare right after a mismatch (a real-time flag must drop, a sticky one must not), and a log shift arriving together with a new mismatch, where a wrongly ordered clear would lose the failure. It also loads an instruction in the same cycle as a failing compare, drives compares after a stop request to show they are ignored, uses an undefined policy code that a loose decoder would treat as stop or bitmap, and hides a difference under the mask so that a design applying the mask to only part of the word would report a false failure or a wrong syndrome.

// File: rtl/mbist_cmp_pkg.sv
// Package: shared types of the MBIST compare unit.
// Assumes: the policy field is decoded once, in mbist_ctrl_reg.
package mbist_cmp_pkg;

    // Failure policy selected by the low control bits.
    typedef enum logic [1:0] {
        POL_RUN    = 2'd0,
        POL_STOP   = 2'd1,
        POL_BITMAP = 2'd2
    } policy_e;

endpackage

// File: rtl/mbist_ctrl_reg.sv
// Module: mbist_ctrl_reg
// Holds the control word of the current test instruction and decodes it
// into the flag mode and the failure policy.
// Assumes: instr_load is a single-cycle pulse; CTRL_W >= 3.
module mbist_ctrl_reg
    import mbist_cmp_pkg::*;
#(
    parameter int CTRL_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_load,
    input  logic [CTRL_W-1:0] instr_ctrl,
    output logic              rt_mode,
    output policy_e           policy
);
    localparam int LOW_W = CTRL_W - 1;
    localparam logic [LOW_W-1:0] CODE_STOP   = LOW_W'(1);
    localparam logic [LOW_W-1:0] CODE_BITMAP = LOW_W'(3);

    logic [CTRL_W-1:0] ctrl_q;
    logic [LOW_W-1:0]  low_bits;

    // Capture the control word on each instruction load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (instr_load)
            ctrl_q <= instr_ctrl;
    end

    assign rt_mode  = ctrl_q[CTRL_W-1];
    assign low_bits = ctrl_q[LOW_W-1:0];

    // Decode the policy; undefined codes fall back to run-to-end.
    always_comb begin
        if (low_bits == CODE_STOP)
            policy = POL_STOP;
        else if (low_bits == CODE_BITMAP)
            policy = POL_BITMAP;
        else
            policy = POL_RUN;
    end

endmodule

// File: rtl/mbist_compare.sv
// Module: mbist_compare
// Masked data comparator. Splits the word into lanes, reduces each lane
// to a hit bit, and produces the overall mismatch and the bit syndrome.
// Assumes: DATA_W is a multiple of LANE_W; mask bit 1 means "ignore".
module mbist_compare #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic              cmp_valid,
    input  logic [DATA_W-1:0] cmp_act,
    input  logic [DATA_W-1:0] cmp_exp,
    input  logic [DATA_W-1:0] cmp_mask,
    output logic              mism,
    output logic [DATA_W-1:0] syndrome
);
    localparam int N_LANE = DATA_W / LANE_W;

    logic [N_LANE-1:0] lane_hit;

    // Bitwise difference with masked positions removed.
    assign syndrome = (cmp_act ^ cmp_exp) & ~cmp_mask;

    // One OR-reduction per lane keeps the final reduction shallow.
    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        assign lane_hit[g] = |syndrome[g*LANE_W +: LANE_W];
    end

    assign mism = cmp_valid & (|lane_hit);

endmodule

// File: rtl/mbist_fail_flag.sv
// Module: mbist_fail_flag
// Fail result register, either real time (follows each accepted compare)
// or sticky (set on first mismatch, cleared by load or log shift-out).
// Assumes: cmp_fire already excludes load cycles and stopped tests.
module mbist_fail_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic instr_load,
    input  logic log_shift,
    input  logic rt_mode,
    input  logic cmp_fire,
    input  logic mism,
    output logic fail_bit
);
    logic fail_q;

    // Update the flag; in sticky mode a new mismatch beats a shift clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fail_q <= 1'b0;
        else if (instr_load)
            fail_q <= 1'b0;
        else if (rt_mode) begin
            if (cmp_fire)
                fail_q <= mism;
        end else
            fail_q <= (fail_q & ~log_shift) | (cmp_fire & mism);
    end

    assign fail_bit = fail_q;

endmodule

// File: rtl/mbist_policy.sv
// Module: mbist_policy
// Applies the failure policy: raises the end-of-test request on a
// stop-on-fail mismatch and emits per-failure log entries in bitmap mode.
// Also gates the compare strobe once the test has been asked to stop.
// Assumes: policy is stable except across instr_load.
module mbist_policy
    import mbist_cmp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_load,
    input  policy_e           policy,
    input  logic              cmp_valid,
    input  logic              mism,
    input  logic [ADDR_W-1:0] cmp_addr,
    input  logic [DATA_W-1:0] syndrome,
    output logic              cmp_fire,
    output logic              end_of_test,
    output logic              log_valid,
    output logic [ADDR_W-1:0] log_addr,
    output logic [DATA_W-1:0] log_syndrome
);
    logic              eot_q;
    logic              logv_q;
    logic [ADDR_W-1:0] laddr_q;
    logic [DATA_W-1:0] lsyn_q;
    logic              fail_hit;

    // A compare counts only outside load cycles and before a stop.
    assign cmp_fire = cmp_valid & ~instr_load & ~eot_q;
    assign fail_hit = cmp_fire & mism;

    // End-of-test request: set on stop-policy failure, held until load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            eot_q <= 1'b0;
        else if (instr_load)
            eot_q <= 1'b0;
        else if (fail_hit && policy == POL_STOP)
            eot_q <= 1'b1;
    end

    // Log strobe: one cycle per bitmap-policy failure.
    always_ff @(posedge clk) begin
        if (!rst_n)
            logv_q <= 1'b0;
        else
            logv_q <= fail_hit && (policy == POL_BITMAP);
    end

    // Log payload: captured alongside each log strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            laddr_q <= '0;
            lsyn_q  <= '0;
        end else if (fail_hit && policy == POL_BITMAP) begin
            laddr_q <= cmp_addr;
            lsyn_q  <= syndrome;
        end
    end

    assign end_of_test  = eot_q;
    assign log_valid    = logv_q;
    assign log_addr     = laddr_q;
    assign log_syndrome = lsyn_q;

endmodule

// File: rtl/mbist_cmp_unit.sv
// Module: mbist_cmp_unit (top)
// MBIST compare and fail-flag unit: masked compare, fail flag in real-time
// or sticky mode, and stop / run-on / bitmap failure policies selected by
// a control word loaded with each test instruction.
// Assumes: instr_load and log_shift are single-cycle pulses from the engine.
module mbist_cmp_unit
    import mbist_cmp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    parameter int CTRL_W = 6,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_load,
    input  logic [CTRL_W-1:0] instr_ctrl,
    input  logic              cmp_valid,
    input  logic [DATA_W-1:0] cmp_act,
    input  logic [DATA_W-1:0] cmp_exp,
    input  logic [DATA_W-1:0] cmp_mask,
    input  logic [ADDR_W-1:0] cmp_addr,
    input  logic              log_shift,
    output logic              fail_bit,
    output logic              end_of_test,
    output logic              log_valid,
    output logic [ADDR_W-1:0] log_addr,
    output logic [DATA_W-1:0] log_syndrome
);
    logic              rt_mode;
    policy_e           policy;
    logic              mism;
    logic [DATA_W-1:0] syndrome;
    logic              cmp_fire;

    // Control word register and decoder.
    mbist_ctrl_reg #(.CTRL_W(CTRL_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_load (instr_load),
        .instr_ctrl (instr_ctrl),
        .rt_mode    (rt_mode),
        .policy     (policy)
    );

    // Masked comparator.
    mbist_compare #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_cmp (
        .cmp_valid (cmp_valid),
        .cmp_act   (cmp_act),
        .cmp_exp   (cmp_exp),
        .cmp_mask  (cmp_mask),
        .mism      (mism),
        .syndrome  (syndrome)
    );

    // Failure policy: stop request and log entries.
    mbist_policy #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_pol (
        .clk          (clk),
        .rst_n        (rst_n),
        .instr_load   (instr_load),
        .policy       (policy),
        .cmp_valid    (cmp_valid),
        .mism         (mism),
        .cmp_addr     (cmp_addr),
        .syndrome     (syndrome),
        .cmp_fire     (cmp_fire),
        .end_of_test  (end_of_test),
        .log_valid    (log_valid),
        .log_addr     (log_addr),
        .log_syndrome (log_syndrome)
    );

    // Fail result bit.
    mbist_fail_flag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_load (instr_load),
        .log_shift  (log_shift),
        .rt_mode    (rt_mode),
        .cmp_fire   (cmp_fire),
        .mism       (mism),
        .fail_bit   (fail_bit)
    );

endmodule

// File: rtl/mbist_cmp_unit_chk.sv
// Module: mbist_cmp_unit_chk
// Property checker bound into mbist_cmp_unit; observes ports and the
// signals passed between its submodules.
module mbist_cmp_unit_chk
    import mbist_cmp_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input logic    instr_load,
    input logic    log_shift,
    input logic    cmp_fire,
    input logic    mism,
    input logic    rt_mode,
    input policy_e policy,
    input logic    fail_bit,
    input logic    end_of_test,
    input logic    log_valid
);
    assert_rt_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_mode && cmp_fire) |=> (fail_bit == $past(mism)));

    assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rt_mode && fail_bit && !instr_load && !log_shift) |=> fail_bit);

    assert_load_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        instr_load |=> (!fail_bit && !end_of_test && !log_valid));

    assert_run_no_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        end_of_test |-> (policy == POL_STOP));

    assert_stop_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (end_of_test && !instr_load) |=> end_of_test);

    assert_stop_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_of_test) |-> $past(mism && cmp_fire));

    assert_log_policy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        log_valid |-> (policy == POL_BITMAP));

    assert_log_each_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == POL_BITMAP && cmp_fire && mism) |=> log_valid);

    assert_fail_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_bit) |-> $past(mism && cmp_fire));

endmodule

bind mbist_cmp_unit mbist_cmp_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_load  (instr_load),
    .log_shift   (log_shift),
    .cmp_fire    (cmp_fire),
    .mism        (mism),
    .rt_mode     (rt_mode),
    .policy      (policy),
    .fail_bit    (fail_bit),
    .end_of_test (end_of_test),
    .log_valid   (log_valid)
);

// File: tb/mbist_cmp_unit_test.sv
`timescale 1ns/1ps
module mbist_cmp_unit_test;

    localparam int DW = 32;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_load = 1'b0;
    logic [5:0]    instr_ctrl = '0;
    logic          cmp_valid = 1'b0;
    logic [DW-1:0] cmp_act = '0;
    logic [DW-1:0] cmp_exp = '0;
    logic [DW-1:0] cmp_mask = '0;
    logic [AW-1:0] cmp_addr = '0;
    logic          log_shift = 1'b0;
    logic          fail_bit, end_of_test, log_valid;
    logic [AW-1:0] log_addr;
    logic [DW-1:0] log_syndrome;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mbist_cmp_unit uut (
        .clk(clk), .rst_n(rst_n), .instr_load(instr_load), .instr_ctrl(instr_ctrl),
        .cmp_valid(cmp_valid), .cmp_act(cmp_act), .cmp_exp(cmp_exp),
        .cmp_mask(cmp_mask), .cmp_addr(cmp_addr), .log_shift(log_shift),
        .fail_bit(fail_bit), .end_of_test(end_of_test), .log_valid(log_valid),
        .log_addr(log_addr), .log_syndrome(log_syndrome)
    );

    typedef struct packed {
        logic          ld;
        logic [5:0]    ctrl;
        logic          vld;
        logic [DW-1:0] act;
        logic [DW-1:0] exp;
        logic [DW-1:0] msk;
        logic [AW-1:0] addr;
        logic          sh;
        logic          e_fail;
        logic          e_eot;
        logic          e_log;
        logic [AW-1:0] e_laddr;
        logic [DW-1:0] e_syn;
        logic [7:0]    req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        // ld ctrl       vld act           exp           msk           addr      sh f  e  l  laddr     syn           req
        '{1'b1, 6'b000000, 1'b0, 32'h0,        32'h0,        32'h0,        16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0,    32'h0,        8'd5},  // R5 load sticky/run
        '{1'b0, 6'b000000, 1'b1, 32'hA5A5A5A5, 32'hA5A5A5A5, 32'h0,        16'h0001, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0,    32'h0,        8'd3},  // R3 match
        '{1'b0, 6'b000000, 1'b1, 32'hA5A5A5A4, 32'hA5A5A5A5, 32'h0,        16'h0002, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0,    32'h0,        8'd6},  // R6 mismatch, no stop
        '{1'b0, 6'b000000, 1'b1, 32'h12345678, 32'h12345678, 32'h0,        16'h0003, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0,    32'h0,        8'd3},  // R3 sticky through match
        '{1'b0, 6'b000000, 1'b0, 32'h0,        32'h0,        32'h0,        16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0,    32'h0,        8'd3},  // R3 idle
        '{1'b0, 6'b000000, 1'b0, 32'h0,        32'h0,        32'h0,        16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0,    32'h0,        8'd4},  // R4 shift clears
        '{1'b1, 6'b100000, 1'b0, 32'h0,        32'h0,        32'h0,        16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0,    32'h0,        8'd5},  // R5 load real-time
        '{1'b0, 6'b100000, 1'b1, 32'hFFFF0000, 32'hFFFF0001, 32'h0,        16'h0010, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0,    32'h0,        8'd2},  // R2 mismatch
        '{1'b0, 6'b100000, 1'b1, 32'h0000FFFF, 32'h0000FFFF, 32'h0,        16'h0011, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0,    32'h0,        8'd2},  // R2 match drops
        '{1'b0, 6'b100000, 1'b1, 32'h000000FF, 32'h00000000, 32'h000000FF, 16'h0012, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0,    32'h0,        8'd10}, // R10 masked diff
        '{1'b1, 6'b000001, 1'b0, 32'h0,        32'h0,        32'h0,        16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0,    32'h0,        8'd5},  // R5 load stop
        '{1'b0, 6'b000001, 1'b1, 32'h00000001, 32'h00000000, 32'h0,        16'h0020, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0,    32'h0,        8'd7},  // R7 stop raised
        '{1'b0, 6'b000001, 1'b1, 32'h5555AAAA, 32'h5555AAAA, 32'h0,        16'h0021, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0,    32'h0,        8'd7},  // R7 held
        '{1'b1, 6'b000011, 1'b0, 32'h0,        32'h0,        32'h0,        16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0,    32'h0,        8'd5},  // R5 load bitmap
        '{1'b0, 6'b000011, 1'b1, 32'h000000F0, 32'h0000000F, 32'h0,        16'h0012, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0012, 32'h000000FF, 8'd8},  // R8 log entry
        '{1'b0, 6'b000011, 1'b1, 32'hCAFEF00D, 32'hCAFEF00D, 32'h0,        16'h0013, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0,    32'h0,        8'd8},  // R8 no entry on match
        '{1'b0, 6'b000011, 1'b1, 32'h80000F0F, 32'h00000000, 32'h0000000F, 16'h0034, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0034, 32'h80000F00, 8'd10}, // R10 syndrome masked
        '{1'b1, 6'b000101, 1'b0, 32'h0,        32'h0,        32'h0,        16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0,    32'h0,        8'd5},  // R5 load odd code
        '{1'b0, 6'b000101, 1'b1, 32'h0F000000, 32'h00000000, 32'h0,        16'h0040, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0,    32'h0,        8'd9},  // R9 runs on
        '{1'b0, 6'b000101, 1'b1, 32'h00F00000, 32'h00000000, 32'h0,        16'h0041, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0,    32'h0,        8'd9}   // R9 still no stop/log
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic drive_idle();
        instr_load = 1'b0; cmp_valid = 1'b0; log_shift = 1'b0;
        cmp_act = '0; cmp_exp = '0; cmp_mask = '0; cmp_addr = '0;
    endtask

    // Drive at negedge, let one rising edge pass, sample 1 ns after it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        drive_idle();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(fail_bit == 1'b0, "R1", "fail_bit after reset", 64'(fail_bit), 64'd0);
        check(end_of_test == 1'b0, "R1", "end_of_test after reset", 64'(end_of_test), 64'd0);
        check(log_valid == 1'b0, "R1", "log_valid after reset", 64'(log_valid), 64'd0);

        // R1: control resets to sticky flag: mismatch then match keeps fail high.
        @(negedge clk);
        cmp_valid = 1'b1; cmp_act = 32'h1; cmp_exp = 32'h0;
        step();
        @(negedge clk);
        cmp_act = 32'h0;
        step();
        check(fail_bit == 1'b1, "R1", "reset control is sticky", 64'(fail_bit), 64'd1);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            string tag;
            @(negedge clk);
            instr_load = VECS[i].ld;  instr_ctrl = VECS[i].ctrl;
            cmp_valid  = VECS[i].vld; cmp_act = VECS[i].act; cmp_exp = VECS[i].exp;
            cmp_mask   = VECS[i].msk; cmp_addr = VECS[i].addr; log_shift = VECS[i].sh;
            step();
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            check(fail_bit == VECS[i].e_fail, tag, "fail_bit", 64'(fail_bit), 64'(VECS[i].e_fail));
            check(end_of_test == VECS[i].e_eot, tag, "end_of_test", 64'(end_of_test), 64'(VECS[i].e_eot));
            check(log_valid == VECS[i].e_log, tag, "log_valid", 64'(log_valid), 64'(VECS[i].e_log));
            if (VECS[i].e_log) begin
                check(log_addr == VECS[i].e_laddr, tag, "log_addr", 64'(log_addr), 64'(VECS[i].e_laddr));
                check(log_syndrome == VECS[i].e_syn, tag, "log_syndrome", 64'(log_syndrome), 64'(VECS[i].e_syn));
            end
        end

        // R5: compare in a load cycle is ignored.
        @(negedge clk);
        drive_idle();
        instr_load = 1'b1; instr_ctrl = 6'b000001;
        cmp_valid = 1'b1; cmp_act = 32'hFF; cmp_exp = 32'h00;
        step();
        check(fail_bit == 1'b0, "R5", "compare in load cycle fail", 64'(fail_bit), 64'd0);
        check(end_of_test == 1'b0, "R5", "compare in load cycle eot", 64'(end_of_test), 64'd0);

        // R7: stop, then a load clears end_of_test.
        @(negedge clk);
        instr_load = 1'b0;
        step();
        check(end_of_test == 1'b1, "R7", "stop after mismatch", 64'(end_of_test), 64'd1);
        @(negedge clk);
        drive_idle();
        instr_load = 1'b1; instr_ctrl = 6'b000000;
        step();
        check(end_of_test == 1'b0, "R7", "load releases stop", 64'(end_of_test), 64'd0);

        // R4: mismatch in the same cycle as a shift keeps the sticky flag.
        @(negedge clk);
        drive_idle();
        cmp_valid = 1'b1; cmp_act = 32'h100; cmp_exp = 32'h0; log_shift = 1'b1;
        step();
        check(fail_bit == 1'b1, "R4", "mismatch beats shift clear", 64'(fail_bit), 64'd1);

        // R11: output changes only after the edge.
        @(negedge clk);
        drive_idle();
        instr_load = 1'b1; instr_ctrl = 6'b100000;
        step();
        @(negedge clk);
        drive_idle();
        cmp_valid = 1'b1; cmp_act = 32'h2; cmp_exp = 32'h0;
        #1;
        check(fail_bit == 1'b0, "R11", "fail before edge", 64'(fail_bit), 64'd0);
        step();
        check(fail_bit == 1'b1, "R11", "fail after edge", 64'(fail_bit), 64'd1);

        // R1: reset mid-run clears the flag.
        @(negedge clk);
        drive_idle();
        rst_n = 1'b0;
        step();
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(fail_bit == 1'b0, "R1", "fail after mid-run reset", 64'(fail_bit), 64'd0);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule